// File: doc/BRIEF.md
# Per-CPU Private Timer with Prescaler

This block is a down-counting timer that a CPU reaches through four word registers: a reload value, the live count, a control word and an event status. A programmable 8-bit divider sets how many clock cycles pass between decrements. When the count runs out, the block sets an event flag. It then either parks at zero or refills itself from the reload value and keeps going. A single-cycle interrupt request fires only when the event flag goes from clear to set.

One copy of the block is placed per CPU, acting either as an ordinary timer or as a watchdog counter. A three-bit instance identity parameter packs the CPU number in its upper bits and the kind in bit 0. From it the block derives which CPU's private interrupt input the request belongs to, and the line number on that CPU. The bus fabric around the block and any reset generation by a watchdog are outside it.

Top module: `cpu_priv_timer`

## Requirements
- R1: After reset every register reads zero (reload value, count, control, status) and `irq_pulse` is low.
- R2: Byte offsets select registers: 0x0 reload value, 0x4 count, 0x8 control, 0xC status. Control bit 0 is enable, bit 1 is auto-refill and bits 15:8 are the divider value P; all other control bits read back as zero. Status bit 0 is the expiry flag and the other status bits read zero.
- R3: While enabled with a nonzero count, the count drops by one every P+1 cycles. The first decrement lands P+1 cycles after the enabling write. A read of offset 0x4 returns the current count. While disabled the count holds.
- R4: When the count steps from 1 to 0, the expiry flag sets. With auto-refill clear, the count then stays at zero and counting stops.
- R5: With auto-refill set, the step that empties the count loads the reload value instead, and counting continues with the same P+1 spacing.
- R6: A control write that turns enable from 0 to 1 while the count is zero and the written auto-refill bit is 1 first copies the reload value into the count. With auto-refill 0 the count stays zero and no expiry occurs.
- R7: Writing the count register, or writing the reload value (which also loads the count), restarts the divider phase. The next decrement is therefore P+1 cycles after that write, even while running.
- R8: Writing 1 to status bit 0 clears the expiry flag, and writing 0 leaves it unchanged. If an expiry happens in the same cycle as a clearing write, the flag ends up set.
- R9: `irq_pulse` is high for exactly one cycle: the first cycle in which the expiry flag reads 1 after having read 0. An expiry while the flag is already set gives no pulse.
- R10: `irq_cpu` equals the upper bits of the instance identity. `irq_line` is 29 when identity bit 0 is 0 (timer) and 30 when it is 1 (watchdog).
- R11: An offset that is not word aligned, or lies above 0xC, reads as zero and ignores writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W (6) | Byte offset of the access |
| wdata | input | CNT_W (32) | Write data |
| rdata | output | CNT_W (32) | Read data for `addr`, combinational |
| irq_pulse | output | 1 | One-cycle interrupt request |
| irq_cpu | output | CPU_W (2) | CPU whose private line receives the request |
| irq_line | output | 5 | Private interrupt line number (29 or 30) |

## Verification
The properties assume that reset is held from time zero until after the first clock edge, and that `wr_en`, `addr` and `wdata` are never unknown once reset is released. The decrement and hold properties only claim anything in cycles without a register write, because a write may legally overwrite the count. The bench drives every input at the falling edge, keeps `wr_en` low outside its write task, and issues at most one write per cycle. Its random divider values, counts and refill choices stay small, so every expiry falls well inside the run.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  // Word index of the registers (addr[3:2]); software depends on this order.
  typedef enum logic [1:0] {
    SEL_RELOAD = 2'd0,
    SEL_COUNT  = 2'd1,
    SEL_CTRL   = 2'd2,
    SEL_STATUS = 2'd3
  } reg_sel_e;

  // Bit positions inside the control word.
  localparam int CTRL_EN_BIT  = 0;
  localparam int CTRL_REL_BIT = 1;
  localparam int CTRL_DIV_LSB = 8;

  // Private interrupt line numbers for the two instance kinds.
  localparam logic [4:0] LINE_TIMER = 5'd29;
  localparam logic [4:0] LINE_WDOG  = 5'd30;

  // Line number selected by the kind bit of the instance identity.
  function automatic logic [4:0] line_of_kind(input logic kind);
    return kind ? LINE_WDOG : LINE_TIMER;
  endfunction

endpackage

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int PRE_W  = 8,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  wdata,
  input  logic [CNT_W-1:0]  cnt_q,
  input  logic              status_q,
  output logic [CNT_W-1:0]  reload_q,
  output logic              en_q,
  output logic              rel_q,
  output logic [PRE_W-1:0]  div_q,
  output logic              wr_reload,
  output logic              wr_count,
  output logic              wr_ctrl,
  output logic              wr_status,
  output logic              en_rise,
  output logic [CNT_W-1:0]  rdata
);

  logic     upper_zero;
  logic     hit;
  reg_sel_e sel;

  // Upper offset bits must be zero for a register hit; only exists when wider than 4.
  generate
    if (ADDR_W > 4) begin : g_upper
      assign upper_zero = (addr[ADDR_W-1:4] == '0);
    end else begin : g_noupper
      assign upper_zero = 1'b1;
    end
  endgenerate

  assign hit = upper_zero && (addr[1:0] == 2'b00);
  assign sel = reg_sel_e'(addr[3:2]);

  assign wr_reload = wr_en && hit && (sel == SEL_RELOAD);
  assign wr_count  = wr_en && hit && (sel == SEL_COUNT);
  assign wr_ctrl   = wr_en && hit && (sel == SEL_CTRL);
  assign wr_status = wr_en && hit && (sel == SEL_STATUS);
  assign en_rise   = wr_ctrl && wdata[CTRL_EN_BIT] && !en_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reload_q <= '0;
      en_q     <= 1'b0;
      rel_q    <= 1'b0;
      div_q    <= '0;
    end else begin
      if (wr_reload) reload_q <= wdata;
      if (wr_ctrl) begin
        en_q  <= wdata[CTRL_EN_BIT];
        rel_q <= wdata[CTRL_REL_BIT];
        div_q <= wdata[CTRL_DIV_LSB +: PRE_W];
      end
    end
  end

  // Control word as seen by software: unused bits read zero.
  function automatic logic [CNT_W-1:0] pack_ctrl(input logic en, input logic rel,
                                                 input logic [PRE_W-1:0] dv);
    logic [CNT_W-1:0] w;
    w = '0;
    w[CTRL_EN_BIT]           = en;
    w[CTRL_REL_BIT]          = rel;
    w[CTRL_DIV_LSB +: PRE_W] = dv;
    return w;
  endfunction

  always_comb begin
    rdata = '0;
    if (hit) begin
      unique case (sel)
        SEL_RELOAD: rdata = reload_q;
        SEL_COUNT:  rdata = cnt_q;
        SEL_CTRL:   rdata = pack_ctrl(en_q, rel_q, div_q);
        SEL_STATUS: rdata = {{(CNT_W-1){1'b0}}, status_q};
        default:    rdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int PRE_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic [PRE_W-1:0] div,
  output logic             tick
);

  logic [PRE_W-1:0] phase_q;
  logic             at_end;

  // ">=" keeps the phase bounded if the divider is lowered mid-count.
  assign at_end = (phase_q >= div);
  assign tick   = run && !restart && at_end;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= '0;
    end else if (restart || !run || at_end) begin
      phase_q <= '0;
    end else begin
      phase_q <= phase_q + 1'b1;
    end
  end

endmodule

// File: rtl/tmr_count.sv
module tmr_count #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             wr_reload,
  input  logic             wr_count,
  input  logic             wr_status,
  input  logic             en_rise,
  input  logic [CNT_W-1:0] wdata,
  input  logic [CNT_W-1:0] reload_q,
  input  logic             rel_q,
  output logic [CNT_W-1:0] cnt_q,
  output logic             status_q,
  output logic             exp_evt
);

  // One decrement step; the last step refills or parks at zero.
  function automatic logic [CNT_W-1:0] step_count(input logic [CNT_W-1:0] c,
                                                  input logic [CNT_W-1:0] rv,
                                                  input logic rel);
    if (c == CNT_W'(1)) return rel ? rv : '0;
    return c - CNT_W'(1);
  endfunction

  logic direct_load;
  logic prime_load;

  assign direct_load = wr_reload || wr_count;
  // Enable edge with an empty count and refill requested in the same write.
  assign prime_load  = en_rise && (cnt_q == '0) && wdata[1];
  assign exp_evt     = tick && !direct_load && (cnt_q == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (direct_load) begin
      cnt_q <= wdata;
    end else if (prime_load) begin
      cnt_q <= reload_q;
    end else if (tick) begin
      cnt_q <= step_count(cnt_q, reload_q, rel_q);
    end
  end

  // Setting beats clearing so a coincident expiry is not lost.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status_q <= 1'b0;
    end else if (exp_evt) begin
      status_q <= 1'b1;
    end else if (wr_status && wdata[0]) begin
      status_q <= 1'b0;
    end
  end

endmodule

// File: rtl/tmr_irq_edge.sv
module tmr_irq_edge #(
  parameter int STAT_W = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STAT_W-1:0] status_q,
  output logic              irq_pulse
);

  logic [STAT_W-1:0] seen_q;

  always_ff @(posedge clk) begin
    if (!rst_n) seen_q <= '0;
    else        seen_q <= status_q;
  end

  // Request only on bits newly risen since the last cycle.
  assign irq_pulse = |(status_q & ~seen_q);

endmodule

// File: rtl/cpu_priv_timer.sv
module cpu_priv_timer
  import tmr_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int PRE_W  = 8,
  parameter int ADDR_W = 6,
  parameter int CPU_W  = 2,
  parameter logic [CPU_W:0] INST_ID = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  wdata,
  output logic [CNT_W-1:0]  rdata,
  output logic              irq_pulse,
  output logic [CPU_W-1:0]  irq_cpu,
  output logic [4:0]        irq_line
);

  logic [CNT_W-1:0] reload_q;
  logic [CNT_W-1:0] cnt_q;
  logic [PRE_W-1:0] div_q;
  logic en_q, rel_q, status_q;
  logic wr_reload, wr_count, wr_ctrl, wr_status, en_rise;
  logic tick, exp_evt, run, restart, stat_clr;

  assign run      = en_q && (cnt_q != '0);
  assign restart  = wr_reload || wr_count || en_rise;
  assign stat_clr = wr_status && wdata[0];

  tmr_regs #(.CNT_W(CNT_W), .PRE_W(PRE_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .cnt_q(cnt_q), .status_q(status_q), .reload_q(reload_q), .en_q(en_q),
    .rel_q(rel_q), .div_q(div_q), .wr_reload(wr_reload), .wr_count(wr_count),
    .wr_ctrl(wr_ctrl), .wr_status(wr_status), .en_rise(en_rise), .rdata(rdata)
  );

  tmr_prescale #(.PRE_W(PRE_W)) u_div (
    .clk(clk), .rst_n(rst_n), .run(run), .restart(restart), .div(div_q), .tick(tick)
  );

  tmr_count #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_reload(wr_reload),
    .wr_count(wr_count), .wr_status(wr_status), .en_rise(en_rise),
    .wdata(wdata), .reload_q(reload_q), .rel_q(rel_q), .cnt_q(cnt_q),
    .status_q(status_q), .exp_evt(exp_evt)
  );

  tmr_irq_edge #(.STAT_W(1)) u_irq (
    .clk(clk), .rst_n(rst_n), .status_q(status_q), .irq_pulse(irq_pulse)
  );

  assign irq_cpu  = INST_ID[CPU_W:1];
  assign irq_line = line_of_kind(INST_ID[0]);

endmodule

// File: rtl/tmr_chk.sv
module tmr_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic             tick,
  input logic             exp_evt,
  input logic             stat_clr,
  input logic             en_q,
  input logic             rel_q,
  input logic             status_q,
  input logic             irq_pulse,
  input logic [CNT_W-1:0] cnt_q
);

  // R9
  irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |-> (status_q && !$past(status_q)));

  // R9
  irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |=> !irq_pulse);

  // R4
  expire_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exp_evt |=> status_q);

  // R4
  park_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && !rel_q && (cnt_q == '0) && !wr_en) |=> (cnt_q == '0));

  // R3
  hold_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !wr_en) |=> $stable(cnt_q));

  // R3
  step_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && (cnt_q > CNT_W'(1)) && !wr_en) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));

  // R8
  clear_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_clr && !exp_evt) |=> !status_q);

endmodule

bind cpu_priv_timer tmr_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .tick(tick), .exp_evt(exp_evt),
  .stat_clr(stat_clr), .en_q(en_q), .rel_q(rel_q), .status_q(status_q),
  .irq_pulse(irq_pulse), .cnt_q(cnt_q)
);

// File: tb/tb_cpu_priv_timer.sv
module tb_cpu_priv_timer;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq_pulse;
  logic [1:0]  irq_cpu;
  logic [4:0]  irq_line;
  logic [31:0] rdata_t;
  logic        irq_t;
  logic [1:0]  cpu_t;
  logic [4:0]  line_t;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  // Watchdog kind on CPU 2.
  cpu_priv_timer #(.INST_ID(3'b101)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .irq_pulse(irq_pulse), .irq_cpu(irq_cpu), .irq_line(irq_line)
  );

  // Timer kind on CPU 1, only its identity outputs are observed.
  cpu_priv_timer #(.INST_ID(3'b010)) dut_t (
    .clk(clk), .rst_n(rst_n), .wr_en(1'b0), .addr(6'd0), .wdata(32'd0),
    .rdata(rdata_t), .irq_pulse(irq_t), .irq_cpu(cpu_t), .irq_line(line_t)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  // Expected values restated from the requirements.
  function automatic logic [31:0] exp_left(input int n, input int p, input int j);
    return 32'(n - j / (p + 1));
  endfunction

  function automatic logic [31:0] ctrl_word(input int p, input bit rel, input bit en);
    return (32'(p) << 8) | (32'(rel) << 1) | 32'(en);
  endfunction

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  logic [31:0] v;

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(6'h0, v); chk("R1 reload", v, 0);
    rd(6'h4, v); chk("R1 count", v, 0);
    rd(6'h8, v); chk("R1 ctrl", v, 0);
    rd(6'hC, v); chk("R1 status", v, 0);
    chk("R1 irq", 32'(irq_pulse), 0);

    // R10 identity
    chk("R10 cpu wdog", 32'(irq_cpu), 2);
    chk("R10 line wdog", 32'(irq_line), 30);
    chk("R10 cpu timer", 32'(cpu_t), 1);
    chk("R10 line timer", 32'(line_t), 29);

    // R2 / R7 map, reload also loads the count
    wr(6'h0, 32'h0000_1234);
    rd(6'h0, v); chk("R2 reload readback", v, 32'h1234);
    rd(6'h4, v); chk("R7 reload loads count", v, 32'h1234);
    wr(6'h8, 32'hFFFF_FF02);
    rd(6'h8, v); chk("R2 ctrl readback", v, 32'h0000_FF02);
    repeat (10) @(negedge clk);
    rd(6'h4, v); chk("R3 hold while disabled", v, 32'h1234);

    // R11 unmapped offsets
    wr(6'h10, 32'hDEAD_BEEF);
    wr(6'h02, 32'h5555_5555);
    wr(6'h0D, 32'h0000_0001);
    rd(6'h10, v); chk("R11 read high", v, 0);
    rd(6'h01, v); chk("R11 read unaligned", v, 0);
    rd(6'h0, v); chk("R11 reload kept", v, 32'h1234);
    rd(6'h8, v); chk("R11 ctrl kept", v, 32'h0000_FF02);
    wr(6'h8, 32'h0);

    // R3 R4 R5 R9 random runs
    for (int it = 0; it < 10; it++) begin
      int  n, p, l, t;
      bit  rel;
      n = 1 + int'($urandom % 12);
      p = int'($urandom % 6);
      l = 3 + int'($urandom % 7);
      rel = bit'($urandom % 2);
      t = n * (p + 1);
      wr(6'h8, 32'h0);
      wr(6'hC, 32'h1);
      wr(6'h0, 32'(l));
      wr(6'h4, 32'(n));
      wr(6'h8, ctrl_word(p, rel, 1'b1));
      for (int j = 0; j < t; j++) begin
        rd(6'h4, v); chk("R3 live count", v, exp_left(n, p, j));
        if (j == t - 1) chk("R9 no early irq", 32'(irq_pulse), 0);
        @(negedge clk);
      end
      rd(6'h4, v); chk(rel ? "R5 refilled" : "R4 parked", v, rel ? 32'(l) : 32'h0);
      rd(6'hC, v); chk("R4 flag set", v, 1);
      chk("R9 irq on rise", 32'(irq_pulse), 1);
      @(negedge clk);
      chk("R9 irq one cycle", 32'(irq_pulse), 0);
      repeat (2 * (p + 1) - 1) @(negedge clk);
      rd(6'h4, v);
      chk(rel ? "R5 continues" : "R4 stays zero", v, rel ? 32'(l - 2) : 32'h0);
      if (rel) begin
        repeat ((l - 2) * (p + 1)) @(negedge clk);
        rd(6'h4, v); chk("R5 second refill", v, 32'(l));
        chk("R9 no pulse while flag set", 32'(irq_pulse), 0);
      end
    end

    // R6 enable edge with empty count and refill
    wr(6'h8, 32'h0);
    wr(6'hC, 32'h1);
    wr(6'h0, 32'd5);
    wr(6'h4, 32'd0);
    wr(6'h8, ctrl_word(0, 1'b1, 1'b1));
    rd(6'h4, v); chk("R6 primed from reload", v, 5);
    @(negedge clk);
    rd(6'h4, v); chk("R6 counting after prime", v, 4);
    wr(6'h8, 32'h0);
    wr(6'h4, 32'd0);
    wr(6'hC, 32'h1);
    wr(6'h8, ctrl_word(0, 1'b0, 1'b1));
    repeat (6) @(negedge clk);
    rd(6'h4, v); chk("R6 no prime without refill", v, 0);
    rd(6'hC, v); chk("R6 no expiry", v, 0);

    // R7 restart while running
    wr(6'h8, 32'h0);
    wr(6'h4, 32'd10);
    wr(6'h8, ctrl_word(3, 1'b0, 1'b1));
    repeat (6) @(negedge clk);
    rd(6'h4, v); chk("R3 divided step", v, exp_left(10, 3, 6));
    wr(6'h4, 32'd20);
    rd(6'h4, v); chk("R7 restart value", v, 20);
    repeat (3) @(negedge clk);
    rd(6'h4, v); chk("R7 phase restarted", v, 20);
    @(negedge clk);
    rd(6'h4, v); chk("R7 first step", v, 19);

    // R8 clear semantics
    wr(6'h8, 32'h0);
    wr(6'h4, 32'd1);
    wr(6'h8, ctrl_word(0, 1'b0, 1'b1));
    @(negedge clk);
    rd(6'hC, v); chk("R8 flag set", v, 1);
    wr(6'hC, 32'h0);
    rd(6'hC, v); chk("R8 write zero keeps", v, 1);
    wr(6'hC, 32'h1);
    rd(6'hC, v); chk("R8 write one clears", v, 0);

    // R8 coincident expiry and clear: expiry lands on the clearing edge
    wr(6'h8, 32'h0);
    wr(6'h4, 32'd2);
    wr(6'h8, ctrl_word(0, 1'b0, 1'b1));
    wr(6'hC, 32'h1);
    rd(6'hC, v); chk("R8 set beats clear", v, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule